// File: doc/BRIEF.md
# Line-State Bit Signaling Engine

This block carries a short bit vector across a physical link by sending one whole line state per bit, while the bit returned by the neighbouring station is read back in the same bit period. A one travels as Halt line state and a zero as Master line state. Software writes a length value and then a transmit vector. The write of the vector starts the exchange: the block asks the symbol generator for the line state of each bit in turn, least significant bit first. It samples the detected received line state at the end of every bit period, which is marked by a time-base pulse.

The received bits build up in a receive vector at the same positions as the bits that were sent. When the last bit has been sampled, the block raises a one-cycle completion pulse and drops its busy flag. A vector write made while an exchange is running is refused, and an error flag records it. A received line state that is neither Halt nor Master is kept as a zero and raises a receive-error flag.

Top module: `line_bit_signaler`

## Requirements
- R1: `tx_ls` drives code 3'd1 (Halt) for a one and 3'd2 (Master) for a zero while `busy` is high, starting with bit 0 of the accepted vector and moving up one bit per time-base pulse. While `busy` is low it drives code 3'd0 (no request).
- R2: The length register keeps only bits 3:0 of `len_wdata`, which hold the bit count minus one (0 gives 1 bit, 15 gives 16 bits). On `len_rdata`, bits 15:4 always read as zero.
- R3: The length is captured only by an accepted vector write, and the value captured is the one held before that cycle. A length write in the same cycle as the vector write, or during the exchange, changes only later exchanges.
- R4: A vector write with `busy` low is accepted. In the next cycle `busy` is high, and `rx_vec`, `rx_err` and `wr_err` are all zero.
- R5: A vector write with `busy` high is ignored, so the running exchange continues with its original data and count. `wr_err` is high from the next cycle until the next accepted write.
- R6: Each bit stays on `tx_ls` until the next `tick` pulse. At that pulse, `rx_ls` is stored in position n of `rx_vec`: 1 for Halt (3'd1) and 0 for Master (3'd2). Positions beyond the count stay zero.
- R7: If any other code is on `rx_ls` at a sampling pulse, that bit is stored as 0. `rx_err` is then high from the next cycle until the next accepted write.
- R8: In the cycle after the pulse that samples the last bit, `done` is high for exactly one cycle and `busy` is already low. A vector write in that cycle is accepted.
- R9: After reset, `busy`, `done`, `wr_err`, `rx_err`, `rx_vec`, `len_rdata` and `tx_ls` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| len_wr | input | 1 | Write strobe for the length register |
| len_wdata | input | 16 | Length write data; only bits 3:0 are kept |
| len_rdata | output | 16 | Length register readback |
| vec_wr | input | 1 | Transmit vector write strobe; starts an exchange |
| vec_wdata | input | 16 | Transmit vector |
| tick | input | 1 | Time-base pulse that ends a bit period |
| rx_ls | input | 3 | Detected received line state code |
| tx_ls | output | 3 | Line state requested from the transmitter |
| busy | output | 1 | An exchange is running |
| rx_vec | output | 16 | Received bit vector |
| done | output | 1 | One-cycle completion pulse |
| wr_err | output | 1 | Vector write refused while busy |
| rx_err | output | 1 | A sampled line state was neither Halt nor Master |

## Verification
Two events can land in the same cycle. The first is a length write together with the vector write that starts an exchange. The bench issues both in one cycle and checks that the exchange uses the old count, then that the following exchange uses the new count. The second is the completion of an exchange together with a new vector write. The bench writes a vector in the exact cycle where `done` is high. It checks that this write is accepted and not flagged, and that the new exchange then sends its own bits from bit 0.

// File: rtl/lbs_pkg.sv
package lbs_pkg;
  typedef enum logic [2:0] {
    LS_NONE   = 3'd0,
    LS_HALT   = 3'd1,
    LS_MASTER = 3'd2,
    LS_IDLE   = 3'd3,
    LS_ACTIVE = 3'd4,
    LS_NOISE  = 3'd5,
    LS_QUIET  = 3'd6,
    LS_UNKN   = 3'd7
  } line_state_e;
endpackage

// File: rtl/lbs_len_reg.sv
module lbs_len_reg #(
  parameter int REG_W = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [LEN_W-1:0] len,
  output logic [REG_W-1:0] rdata
);
  logic [LEN_W-1:0] len_q, len_d;

  always_comb begin
    len_d = len_q;
    if (wr) len_d = wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= '0;
    else        len_q <= len_d;
  end

  assign len   = len_q;
  assign rdata = {{(REG_W-LEN_W){1'b0}}, len_q};

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[REG_W-1:LEN_W] == '0);
endmodule

// File: rtl/lbs_tx_seq.sv
module lbs_tx_seq
  import lbs_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic [LEN_W-1:0] len,
  input  logic             tick,
  output logic [2:0]       tx_ls,
  output logic             busy,
  output logic             done,
  output logic             wr_err,
  output logic             start,
  output logic             sample,
  output logic [LEN_W-1:0] bit_idx
);
  logic             busy_q, busy_d;
  logic             done_q, done_d;
  logic             werr_q, werr_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic [LEN_W-1:0] last_q, last_d;
  logic [VEC_W-1:0] sh_q, sh_d;
  logic             accept, fin;

  assign accept = vec_wr & ~busy_q;
  assign sample = busy_q & tick;
  assign fin    = sample & (cnt_q == last_q);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    last_d = last_q;
    sh_d   = sh_q;
    werr_d = werr_q;
    done_d = fin;
    if (accept) begin
      busy_d = 1'b1;
      cnt_d  = '0;
      last_d = len;
      sh_d   = vec_wdata;
      werr_d = 1'b0;
    end else begin
      if (vec_wr) werr_d = 1'b1;
      if (fin) begin
        busy_d = 1'b0;
      end else if (sample) begin
        cnt_d = cnt_q + LEN_W'(1);
        sh_d  = sh_q >> 1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      werr_q <= 1'b0;
      cnt_q  <= '0;
      last_q <= '0;
      sh_q   <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      werr_q <= werr_d;
      cnt_q  <= cnt_d;
      last_q <= last_d;
      sh_q   <= sh_d;
    end
  end

  always_comb begin
    if (!busy_q)      tx_ls = LS_NONE;
    else if (sh_q[0]) tx_ls = LS_HALT;
    else              tx_ls = LS_MASTER;
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign wr_err  = werr_q;
  assign start   = accept;
  assign bit_idx = cnt_q;

  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && !busy_q) |=> (busy_q && !werr_q));
  a_r5_refuse_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_wr && busy_q) |=> werr_q);
  a_r3_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && $past(busy_q)) |-> $stable(last_q));
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  a_r1_idle_none: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (tx_ls == LS_NONE));
endmodule

// File: rtl/lbs_rx_cap.sv
module lbs_rx_cap
  import lbs_pkg::*;
#(
  parameter int VEC_W = 16,
  parameter int LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sample_en,
  input  logic [LEN_W-1:0] bit_idx,
  input  logic [2:0]       rx_ls,
  output logic [VEC_W-1:0] rx_vec,
  output logic             rx_err
);
  logic [VEC_W-1:0] vec_q, vec_d;
  logic             err_q, err_d;
  logic             is_halt, is_master;

  assign is_halt   = (rx_ls == LS_HALT);
  assign is_master = (rx_ls == LS_MASTER);

  for (genvar i = 0; i < VEC_W; i++) begin : g_bit
    always_comb begin
      vec_d[i] = vec_q[i];
      if (start)
        vec_d[i] = 1'b0;
      else if (sample_en && (bit_idx == LEN_W'(i)))
        vec_d[i] = is_halt;
    end
  end

  always_comb begin
    err_d = err_q;
    if (start)                                err_d = 1'b0;
    else if (sample_en && !is_halt && !is_master) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q <= '0;
      err_q <= 1'b0;
    end else begin
      vec_q <= vec_d;
      err_q <= err_d;
    end
  end

  assign rx_vec = vec_q;
  assign rx_err = err_q;

  a_r7_err_source: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_q) |-> $past(sample_en));
  a_r4_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (vec_q == '0 && !err_q));
endmodule

// File: rtl/line_bit_signaler.sv
module line_bit_signaler #(
  parameter int VEC_W = 16,
  parameter int REG_W = 16,
  localparam int LEN_W = $clog2(VEC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             len_wr,
  input  logic [REG_W-1:0] len_wdata,
  output logic [REG_W-1:0] len_rdata,
  input  logic             vec_wr,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             tick,
  input  logic [2:0]       rx_ls,
  output logic [2:0]       tx_ls,
  output logic             busy,
  output logic [VEC_W-1:0] rx_vec,
  output logic             done,
  output logic             wr_err,
  output logic             rx_err
);
  logic [LEN_W-1:0] len;
  logic [LEN_W-1:0] bit_idx;
  logic             start, sample;

  lbs_len_reg #(.REG_W(REG_W), .LEN_W(LEN_W)) u_len (
    .clk(clk), .rst_n(rst_n), .wr(len_wr), .wdata(len_wdata),
    .len(len), .rdata(len_rdata)
  );

  lbs_tx_seq #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .vec_wr(vec_wr), .vec_wdata(vec_wdata),
    .len(len), .tick(tick), .tx_ls(tx_ls), .busy(busy), .done(done),
    .wr_err(wr_err), .start(start), .sample(sample), .bit_idx(bit_idx)
  );

  lbs_rx_cap #(.VEC_W(VEC_W), .LEN_W(LEN_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .start(start), .sample_en(sample),
    .bit_idx(bit_idx), .rx_ls(rx_ls), .rx_vec(rx_vec), .rx_err(rx_err)
  );
endmodule

// File: tb/tb_line_bit_signaler.sv
module tb_line_bit_signaler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        len_wr = 1'b0;
  logic [15:0] len_wdata = '0;
  logic [15:0] len_rdata;
  logic        vec_wr = 1'b0;
  logic [15:0] vec_wdata = '0;
  logic        tick = 1'b0;
  logic [2:0]  rx_ls = 3'd0;
  logic [2:0]  tx_ls;
  logic        busy, done, wr_err, rx_err;
  logic [15:0] rx_vec;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  line_bit_signaler dut (
    .clk(clk), .rst_n(rst_n), .len_wr(len_wr), .len_wdata(len_wdata),
    .len_rdata(len_rdata), .vec_wr(vec_wr), .vec_wdata(vec_wdata),
    .tick(tick), .rx_ls(rx_ls), .tx_ls(tx_ls), .busy(busy),
    .rx_vec(rx_vec), .done(done), .wr_err(wr_err), .rx_err(rx_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_len(input logic [15:0] v);
    len_wr = 1'b1; len_wdata = v;
    step();
    len_wr = 1'b0;
  endtask

  task automatic start_vec(input logic [15:0] v);
    vec_wr = 1'b1; vec_wdata = v;
    step();
    vec_wr = 1'b0;
    check(busy == 1'b1, "R4 busy after write", int'(busy), 1);
    check(rx_vec == 16'h0 && !rx_err && !wr_err, "R4 clear on start", int'(rx_vec), 0);
  endtask

  // runs n bits; rx gives returned bit values, bad marks positions carrying Idle
  task automatic send_bits(input logic [15:0] v, input int n,
                           input logic [15:0] rx, input logic [15:0] bad);
    logic [15:0] exp_vec = '0;
    logic        exp_err = 1'b0;
    for (int i = 0; i < n; i++) begin
      logic [2:0] e = v[i] ? 3'd1 : 3'd2;
      check(tx_ls == e, "R1 tx code", int'(tx_ls), int'(e));
      step();
      check(tx_ls == e && busy, "R6 hold until tick", int'(tx_ls), int'(e));
      rx_ls = bad[i] ? 3'd3 : (rx[i] ? 3'd1 : 3'd2);
      if (!bad[i]) exp_vec[i] = rx[i];
      else         exp_err = 1'b1;
      tick = 1'b1;
      step();
      tick = 1'b0;
      rx_ls = 3'd0;
      if (i < n - 1) check(done == 1'b0, "R8 no early done", int'(done), 0);
    end
    check(done == 1'b1 && busy == 1'b0, "R8 done with busy low",
          int'({done, busy}), 2);
    check(tx_ls == 3'd0, "R1 none after end", int'(tx_ls), 0);
    check(rx_vec == exp_vec, "R6 receive vector", int'(rx_vec), int'(exp_vec));
    check(rx_err == exp_err, "R7 receive error", int'(rx_err), int'(exp_err));
  endtask

  task automatic t_reset();
    check(busy == 0 && done == 0 && wr_err == 0 && rx_err == 0, "R9 flags",
          int'({busy, done, wr_err, rx_err}), 0);
    check(rx_vec == 0 && len_rdata == 0 && tx_ls == 0, "R9 data",
          int'(rx_vec), 0);
  endtask

  task automatic t_len_reg();
    set_len(16'hFFF5);
    check(len_rdata == 16'h0005, "R2 upper bits zero", int'(len_rdata), 5);
  endtask

  task automatic t_basic();
    set_len(16'h0005);
    start_vec(16'hFF2D);
    send_bits(16'hFF2D, 6, 16'h0013, 16'h0);
    step();
    check(done == 1'b0, "R8 done single cycle", int'(done), 0);
  endtask

  task automatic t_full();
    set_len(16'h000F);
    start_vec(16'hA5C3);
    send_bits(16'hA5C3, 16, 16'h5A3C, 16'h0);
    step();
  endtask

  task automatic t_single();
    set_len(16'h0000);
    start_vec(16'h0001);
    send_bits(16'h0001, 1, 16'hFFFF, 16'h0);
    check(rx_vec == 16'h0001, "R6 positions beyond count zero", int'(rx_vec), 1);
    step();
  endtask

  task automatic t_refuse();
    set_len(16'h0003);
    start_vec(16'h0009);
    vec_wr = 1'b1; vec_wdata = 16'h0006;
    step();
    vec_wr = 1'b0;
    check(wr_err == 1'b1 && busy == 1'b1, "R5 refused write flagged",
          int'({wr_err, busy}), 3);
    send_bits(16'h0009, 4, 16'h000A, 16'h0);
    check(wr_err == 1'b1, "R5 flag sticky", int'(wr_err), 1);
    step();
    start_vec(16'h0000);
    send_bits(16'h0000, 4, 16'h0, 16'h0);
    step();
  endtask

  task automatic t_len_same_cycle();
    set_len(16'h0002);
    len_wr = 1'b1; len_wdata = 16'h0007;
    vec_wr = 1'b1; vec_wdata = 16'h00FF;
    step();
    len_wr = 1'b0; vec_wr = 1'b0;
    check(busy == 1'b1, "R3 start with length write", int'(busy), 1);
    set_len(16'h0001);
    send_bits(16'h00FF, 3, 16'h0005, 16'h0);
    step();
    check(len_rdata == 16'h0001, "R3 length readback", int'(len_rdata), 1);
    set_len(16'h0007);
    start_vec(16'h0055);
    send_bits(16'h0055, 8, 16'h00C3, 16'h0);
    step();
  endtask

  task automatic t_bad_rx();
    set_len(16'h0004);
    start_vec(16'h001F);
    send_bits(16'h001F, 5, 16'h001F, 16'h0004);
    step();
  endtask

  task automatic t_write_on_done();
    set_len(16'h0001);
    start_vec(16'h0002);
    send_bits(16'h0002, 2, 16'h0001, 16'h0);
    vec_wr = 1'b1; vec_wdata = 16'h0001;
    step();
    vec_wr = 1'b0;
    check(busy == 1'b1 && wr_err == 1'b0, "R8 write in done cycle accepted",
          int'({busy, wr_err}), 2);
    send_bits(16'h0001, 2, 16'h0002, 16'h0);
    step();
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    step();
    step();
    t_reset();
    rst_n = 1'b1;
    step();
    t_reset();
    t_len_reg();
    t_basic();
    t_full();
    t_single();
    t_refuse();
    t_len_same_cycle();
    t_bad_rx();
    t_write_on_done();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule